// File: doc/BRIEF.md
# DRAM Bank Timing Checker

This block is a passive watcher placed on the command bus of a four-bank double-data-rate SDRAM. On every rising clock edge it takes chip select, the three command strobes, the two bank-select bits, address bit A10 and the three low address bits. It decodes one command per edge and keeps its own record of which banks hold an open row. It also records how many cycles have passed since each event that starts a timing window.

A command that arrives too early after an earlier one is flagged. So is a command that does not fit the current bank state. On the following cycle the block gives a single-cycle pulse, a 4-bit violation code and the bank concerned. Every minimum spacing is a parameter counted in clock cycles. The block never holds back or changes a command. Its bank-state record follows every command as issued, including commands that caused a violation.

Top module: `dram_cmd_timing_mon`

## Requirements
- R1: With chip select low, {RAS#,CAS#,WE#} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 111 no-op. With chip select high, nothing is decoded. No-ops, deselected cycles and the unlisted pattern 110 never raise the violation pulse. The pulse, code and bank outputs appear on the clock after the offending edge and last one cycle.
- R2: A read or write to an idle bank gives code 1. An activate to an open bank gives code 2. A precharge with A10 high closes every bank. A precharge with A10 low closes only the bank selected by BA1:BA0.
- R3: A refresh while any bank is open gives code 3. A mode set while any bank is open gives code 4. Both report the lowest-numbered open bank.
- R4: A read to an open bank fewer than T_RCD_RD (4) cycles after that bank's activate gives code 5. A write fewer than T_RCD_WR (2) cycles after it gives code 6.
- R5: An activate fewer than T_RC (12) cycles after the previous activate of the same bank gives code 7. An activate fewer than T_RRD (3) cycles after an activate of any other bank gives code 8.
- R6: A precharge reaching an open bank fewer than T_RAS (8) cycles after that bank's activate gives code 9. For a precharge to all banks, the lowest such bank is reported.
- R7: Code 10 is given when an activate comes fewer than T_RP (4) cycles after the precharge that closed its bank. It is also given when a refresh or mode set comes within T_RP of any bank's closing precharge; the lowest such bank is reported.
- R8: Any decoded command other than a no-op gives code 11 if it comes fewer than T_RFC (14) cycles after a refresh. It gives code 12 if it comes fewer than T_MRD (2) cycles after a mode set.
- R9: H is half the burst length. A mode set with BA0 low loads it from A2:A0: 1 gives 1, 2 gives 2, 3 gives 4, and any other value keeps H. A mode set with BA0 high leaves H unchanged. H is 2 after reset.
- R10: A write burst ends H cycles after its write command. A read at or before the end of the burst gives code 14. A read within T_CDLR (2) cycles after the burst ends gives code 15. A precharge reaching an open bank within T_WR (3) cycles after the end of that bank's write burst gives code 13.
- R11: When several rules fail on one command, the lowest code wins. The bank reported is the command's own bank, except in the cases where R3, R6, R7 and R10 name another bank.
- R12: After reset the outputs are zero, every bank is idle and no timing window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | All-bank flag for precharge |
| mode_bits | input | 3 | Address bits A2:A0, burst field during mode set |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 4 | Violation code, 0 when no violation |
| viol_bank_o | output | 2 | Bank involved in the violation |

## Verification
The stimulus runs one command per clock. It covers a legal open, write, read and close flow, and dense back-to-back commands in which two or three rules fail at once, so the lowest-code rule can be told apart from the others. Reads are placed exactly at the end of a write burst, one cycle after it and at the recovery limit. These placements separate the in-burst code, the recovery code and a clean read. A write burst is also timed after both a plain and an extended mode set, which shows whether the burst length was taken from the right one. A deselected activate followed by a read shows whether chip select really blocks decoding.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int BANKS = 4;
    localparam int BA_W  = $clog2(BANKS);

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_OTHER
    } cmd_e;

    typedef enum logic [3:0] {
        V_NONE      = 4'd0,
        V_IDLE_COL  = 4'd1,
        V_ACT_OPEN  = 4'd2,
        V_REF_OPEN  = 4'd3,
        V_MRS_OPEN  = 4'd4,
        V_RCD_RD    = 4'd5,
        V_RCD_WR    = 4'd6,
        V_RC        = 4'd7,
        V_RRD       = 4'd8,
        V_RAS       = 4'd9,
        V_RP        = 4'd10,
        V_RFC       = 4'd11,
        V_MRD       = 4'd12,
        V_WR        = 4'd13,
        V_RD_WBURST = 4'd14,
        V_WTR       = 4'd15
    } viol_e;

    typedef struct packed {
        logic            hit;
        viol_e           code;
        logic [BA_W-1:0] bank;
    } viol_t;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_MRS;
                3'b111:  c = CMD_NOP;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

    // Half burst length from the burst field; unknown codes keep the old value.
    function automatic logic [3:0] mode_half(input logic [2:0] field, input logic [3:0] cur);
        logic [3:0] h;
        case (field)
            3'd1:    h = 4'd1;
            3'd2:    h = 4'd2;
            3'd3:    h = 4'd4;
            default: h = cur;
        endcase
        return h;
    endfunction

    function automatic logic [BA_W-1:0] lowest_set(input logic [BANKS-1:0] v);
        logic [BA_W-1:0] r;
        r = '0;
        for (int i = BANKS - 1; i >= 0; i--) begin
            if (v[i]) r = BA_W'(i);
        end
        return r;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dtm_age_ctr.sv
module dtm_age_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt_i,
    output logic [W-1:0] age_o
);
    localparam logic [W-1:0] SAT = '1;

    // Cycles since the last event, saturating; reset means "long ago".
    always_ff @(posedge clk) begin
        if (rst) begin
            age_o <= SAT;
        end else if (evt_i) begin
            age_o <= W'(1);
        end else if (age_o != SAT) begin
            age_o <= age_o + W'(1);
        end
    end
endmodule

// File: rtl/dtm_bank_track.sv
module dtm_bank_track #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         act_i,
    input  logic         pre_i,
    input  logic         wr_i,
    output logic         open_o,
    output logic [W-1:0] act_age_o,
    output logic [W-1:0] pre_age_o,
    output logic [W-1:0] wr_age_o
);
    logic closing;

    assign closing = pre_i && open_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
        end else if (act_i) begin
            open_o <= 1'b1;
        end else if (pre_i) begin
            open_o <= 1'b0;
        end
    end

    dtm_age_ctr #(.W(W)) u_act_age (.clk(clk), .rst(rst), .evt_i(act_i),   .age_o(act_age_o));
    dtm_age_ctr #(.W(W)) u_pre_age (.clk(clk), .rst(rst), .evt_i(closing), .age_o(pre_age_o));
    dtm_age_ctr #(.W(W)) u_wr_age  (.clk(clk), .rst(rst), .evt_i(wr_i),    .age_o(wr_age_o));
endmodule

// File: rtl/dtm_global_track.sv
module dtm_global_track #(
    parameter int W      = 5,
    parameter int DEF_HB = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_i,
    input  logic         mrs_i,
    input  logic         mrs_plain_i,
    input  logic [2:0]   mode_i,
    input  logic         wr_i,
    output logic [W-1:0] ref_age_o,
    output logic [W-1:0] mrs_age_o,
    output logic [W-1:0] wr_age_o,
    output logic [3:0]   hb_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hb_o <= 4'(DEF_HB);
        end else if (mrs_i && mrs_plain_i) begin
            hb_o <= dtm_pkg::mode_half(mode_i, hb_o);
        end
    end

    dtm_age_ctr #(.W(W)) u_ref_age (.clk(clk), .rst(rst), .evt_i(ref_i), .age_o(ref_age_o));
    dtm_age_ctr #(.W(W)) u_mrs_age (.clk(clk), .rst(rst), .evt_i(mrs_i), .age_o(mrs_age_o));
    dtm_age_ctr #(.W(W)) u_wr_age  (.clk(clk), .rst(rst), .evt_i(wr_i),  .age_o(wr_age_o));
endmodule

// File: rtl/dtm_rule_check.sv
module dtm_rule_check
    import dtm_pkg::*;
#(
    parameter int W        = 5,
    parameter int T_RCD_RD = 4,
    parameter int T_RCD_WR = 2,
    parameter int T_RC     = 12,
    parameter int T_RAS    = 8,
    parameter int T_RP     = 4,
    parameter int T_RFC    = 14,
    parameter int T_RRD    = 3,
    parameter int T_MRD    = 2,
    parameter int T_WR     = 3,
    parameter int T_CDLR   = 2
) (
    input  cmd_e                     cmd_i,
    input  logic [BA_W-1:0]          ba_i,
    input  logic                     a10_i,
    input  logic [BANKS-1:0]         open_i,
    input  logic [BANKS-1:0][W-1:0]  act_age_i,
    input  logic [BANKS-1:0][W-1:0]  pre_age_i,
    input  logic [BANKS-1:0][W-1:0]  wr_age_i,
    input  logic [W-1:0]             wr_any_age_i,
    input  logic [W-1:0]             ref_age_i,
    input  logic [W-1:0]             mrs_age_i,
    input  logic [3:0]               hb_i,
    output viol_t                    viol_o
);
    localparam logic [W-1:0] L_RCDR = W'(T_RCD_RD);
    localparam logic [W-1:0] L_RCDW = W'(T_RCD_WR);
    localparam logic [W-1:0] L_RC   = W'(T_RC);
    localparam logic [W-1:0] L_RAS  = W'(T_RAS);
    localparam logic [W-1:0] L_RP   = W'(T_RP);
    localparam logic [W-1:0] L_RFC  = W'(T_RFC);
    localparam logic [W-1:0] L_RRD  = W'(T_RRD);
    localparam logic [W-1:0] L_MRD  = W'(T_MRD);
    localparam logic [W-1:0] L_WR   = W'(T_WR);
    localparam logic [W-1:0] L_CDLR = W'(T_CDLR);
    localparam int NCODE = 16;

    logic [W-1:0]      hb_w, wr_lim, cdlr_lim;
    logic [BANKS-1:0]  tgt, ras_bad, wr_bad, rp_bad, rrd_bad;
    logic              is_col, is_real;
    logic [NCODE-1:0]  fl;
    logic [BA_W-1:0]   fb [NCODE];

    assign hb_w     = W'(hb_i);
    assign wr_lim   = L_WR + hb_w;
    assign cdlr_lim = L_CDLR + hb_w;
    assign is_col   = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
    assign is_real  = (cmd_i != CMD_NOP) && (cmd_i != CMD_OTHER);

    // Per-bank windows
    for (genvar c = 0; c < BANKS; c++) begin : g_bank_rules
        assign tgt[c]     = (cmd_i == CMD_PRE) && (a10_i || (ba_i == BA_W'(c)));
        assign ras_bad[c] = tgt[c] && open_i[c] && (act_age_i[c] < L_RAS);
        assign wr_bad[c]  = tgt[c] && open_i[c] && (wr_age_i[c] < wr_lim);
        assign rp_bad[c]  = pre_age_i[c] < L_RP;
        assign rrd_bad[c] = (ba_i != BA_W'(c)) && (act_age_i[c] < L_RRD);
    end

    always_comb begin
        fl = '0;
        for (int k = 0; k < NCODE; k++) fb[k] = ba_i;

        fl[V_IDLE_COL] = is_col && !open_i[ba_i];
        fl[V_ACT_OPEN] = (cmd_i == CMD_ACT) && open_i[ba_i];
        fl[V_REF_OPEN] = (cmd_i == CMD_REF) && (|open_i);
        fb[V_REF_OPEN] = lowest_set(open_i);
        fl[V_MRS_OPEN] = (cmd_i == CMD_MRS) && (|open_i);
        fb[V_MRS_OPEN] = lowest_set(open_i);
        fl[V_RCD_RD]   = (cmd_i == CMD_RD) && open_i[ba_i] && (act_age_i[ba_i] < L_RCDR);
        fl[V_RCD_WR]   = (cmd_i == CMD_WR) && open_i[ba_i] && (act_age_i[ba_i] < L_RCDW);
        fl[V_RC]       = (cmd_i == CMD_ACT) && (act_age_i[ba_i] < L_RC);
        fl[V_RRD]      = (cmd_i == CMD_ACT) && (|rrd_bad);
        fl[V_RAS]      = |ras_bad;
        fb[V_RAS]      = lowest_set(ras_bad);
        if (cmd_i == CMD_ACT) begin
            fl[V_RP] = pre_age_i[ba_i] < L_RP;
        end else if ((cmd_i == CMD_REF) || (cmd_i == CMD_MRS)) begin
            fl[V_RP] = |rp_bad;
            fb[V_RP] = lowest_set(rp_bad);
        end
        fl[V_RFC]       = is_real && (ref_age_i < L_RFC);
        fl[V_MRD]       = is_real && (mrs_age_i < L_MRD);
        fl[V_WR]        = |wr_bad;
        fb[V_WR]        = lowest_set(wr_bad);
        fl[V_RD_WBURST] = (cmd_i == CMD_RD) && (wr_any_age_i <= hb_w);
        fl[V_WTR]       = (cmd_i == CMD_RD) && (wr_any_age_i < cdlr_lim);
    end

    // Lowest code wins
    always_comb begin
        viol_o = '0;
        for (int k = NCODE - 1; k >= 1; k--) begin
            if (fl[k]) begin
                viol_o.hit  = 1'b1;
                viol_o.code = viol_e'(4'(k));
                viol_o.bank = fb[k];
            end
        end
    end
endmodule

// File: rtl/dram_cmd_timing_mon.sv
module dram_cmd_timing_mon
    import dtm_pkg::*;
#(
    parameter int T_RCD_RD = 4,
    parameter int T_RCD_WR = 2,
    parameter int T_RC     = 12,
    parameter int T_RAS    = 8,
    parameter int T_RP     = 4,
    parameter int T_RFC    = 14,
    parameter int T_RRD    = 3,
    parameter int T_MRD    = 2,
    parameter int T_WR     = 3,
    parameter int T_CDLR   = 2,
    parameter int DEF_HB   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    input  logic [2:0] mode_bits,
    output logic       viol_o,
    output logic [3:0] viol_code_o,
    output logic [1:0] viol_bank_o
);
    localparam int MAX_HB  = 4;
    localparam int MAX_LIM = imax(imax(imax(T_RC, T_RFC), imax(T_RAS, T_RP)),
                             imax(imax(T_RCD_RD, T_RCD_WR), imax(imax(T_RRD, T_MRD),
                             imax(T_WR, T_CDLR) + MAX_HB)));
    localparam int AGE_W   = $clog2(MAX_LIM + 1) + 1;

    cmd_e                         cmd;
    logic [BANKS-1:0]             open_v;
    logic [BANKS-1:0][AGE_W-1:0]  act_age, pre_age, wr_age;
    logic [AGE_W-1:0]             wr_any_age, ref_age, mrs_age;
    logic [3:0]                   hb;
    viol_t                        viol_d, viol_q;

    assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

    for (genvar c = 0; c < BANKS; c++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(c));
        dtm_bank_track #(.W(AGE_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .act_i     ((cmd == CMD_ACT) && sel),
            .pre_i     ((cmd == CMD_PRE) && (sel || a10)),
            .wr_i      ((cmd == CMD_WR) && sel),
            .open_o    (open_v[c]),
            .act_age_o (act_age[c]),
            .pre_age_o (pre_age[c]),
            .wr_age_o  (wr_age[c])
        );
    end

    dtm_global_track #(.W(AGE_W), .DEF_HB(DEF_HB)) u_glob (
        .clk         (clk),
        .rst         (rst),
        .ref_i       (cmd == CMD_REF),
        .mrs_i       (cmd == CMD_MRS),
        .mrs_plain_i (!ba[0]),
        .mode_i      (mode_bits),
        .wr_i        (cmd == CMD_WR),
        .ref_age_o   (ref_age),
        .mrs_age_o   (mrs_age),
        .wr_age_o    (wr_any_age),
        .hb_o        (hb)
    );

    dtm_rule_check #(
        .W(AGE_W), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR), .T_RC(T_RC),
        .T_RAS(T_RAS), .T_RP(T_RP), .T_RFC(T_RFC), .T_RRD(T_RRD),
        .T_MRD(T_MRD), .T_WR(T_WR), .T_CDLR(T_CDLR)
    ) u_rules (
        .cmd_i        (cmd),
        .ba_i         (ba),
        .a10_i        (a10),
        .open_i       (open_v),
        .act_age_i    (act_age),
        .pre_age_i    (pre_age),
        .wr_age_i     (wr_age),
        .wr_any_age_i (wr_any_age),
        .ref_age_i    (ref_age),
        .mrs_age_i    (mrs_age),
        .hb_i         (hb),
        .viol_o       (viol_d)
    );

    always_ff @(posedge clk) begin
        if (rst) viol_q <= '0;
        else     viol_q <= viol_d;
    end

    assign viol_o      = viol_q.hit;
    assign viol_code_o = viol_q.code;
    assign viol_bank_o = viol_q.bank;
endmodule

// File: rtl/dtm_mon_chk.sv
module dtm_mon_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       viol_o,
    input logic [3:0] viol_code_o,
    input logic [1:0] viol_bank_o
);
    // R1
    pulse_has_code_chk: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (viol_code_o != 4'd0));
    // R1
    quiet_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !viol_o |-> (viol_code_o == 4'd0 && viol_bank_o == 2'd0));
    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !viol_o);
    // R1
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ras_n && cas_n && we_n) |=> !viol_o);
    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!viol_o && viol_code_o == 4'd0));
    // R2
    act_open_src_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_o && viol_code_o == 4'd2) |-> $past(!cs_n && !ras_n && cas_n && we_n));
    // R3
    ref_open_src_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_o && viol_code_o == 4'd3) |-> $past(!cs_n && !ras_n && !cas_n && we_n));
    // R10
    read_recov_src_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_o && viol_code_o >= 4'd14) |-> $past(!cs_n && ras_n && !cas_n && we_n));
endmodule

bind dram_cmd_timing_mon dtm_mon_chk u_dtm_mon_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .viol_o      (viol_o),
    .viol_code_o (viol_code_o),
    .viol_bank_o (viol_bank_o)
);

// File: tb/dram_cmd_timing_mon_bench.sv
module dram_cmd_timing_mon_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD_RD = 4, T_RCD_WR = 2, T_RC = 12, T_RAS = 8, T_RP = 4;
    localparam int T_RFC = 14, T_RRD = 3, T_MRD = 2, T_WR = 3, T_CDLR = 2;
    localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_REF = 5, K_MRS = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [2:0] mode_bits = 3'd0;
    logic viol_o;
    logic [3:0] viol_code_o;
    logic [1:0] viol_bank_o;

    int n_chk = 0, n_bad = 0, t = 0;
    bit done = 0;
    bit open_m [4];
    int last_act [4], last_pre [4], last_wr [4];
    int last_wr_any, last_ref, last_mrs, hb_m;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_cmd_timing_mon u_dram_cmd_timing_mon (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .mode_bits(mode_bits),
        .viol_o(viol_o), .viol_code_o(viol_code_o), .viol_bank_o(viol_bank_o)
    );

    function automatic string tag_of(input int code);
        case (code)
            0:       return "R1";
            1, 2:    return "R2";
            3, 4:    return "R3";
            5, 6:    return "R4";
            7, 8:    return "R5";
            9:       return "R6";
            10:      return "R7";
            11, 12:  return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check_eq(input int act, input int exp, input string tag, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one command, predict the result, compare one cycle later.
    task automatic issue_raw(input bit cs, input int kind, input int b, input bit all, input int mb);
        int code = 0, bk = 0, lo_open = -1, ras_lo = -1, rp_lo = -1, wr_lo = -1;
        bit rrd = 0, is_real;
        int k;
        k = cs ? K_NOP : kind;
        cs_n = cs; ba = 2'(b); a10 = all; mode_bits = 3'(mb);
        case (kind)
            K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            K_RD:    {ras_n, cas_n, we_n} = 3'b101;
            K_WR:    {ras_n, cas_n, we_n} = 3'b100;
            K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            K_REF:   {ras_n, cas_n, we_n} = 3'b001;
            K_MRS:   {ras_n, cas_n, we_n} = 3'b000;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        is_real = (k != K_NOP);
        for (int c = 3; c >= 0; c--) begin
            bit tg;
            tg = (k == K_PRE) && (all || c == b);
            if (open_m[c]) lo_open = c;
            if (tg && open_m[c] && (t - last_act[c] < T_RAS)) ras_lo = c;
            if (tg && open_m[c] && (t - last_wr[c] < hb_m + T_WR)) wr_lo = c;
            if (t - last_pre[c] < T_RP) rp_lo = c;
            if (c != b && (t - last_act[c] < T_RRD)) rrd = 1;
        end
        if ((k == K_RD || k == K_WR) && !open_m[b]) begin code = 1; bk = b; end
        else if (k == K_ACT && open_m[b]) begin code = 2; bk = b; end
        else if (k == K_REF && lo_open >= 0) begin code = 3; bk = lo_open; end
        else if (k == K_MRS && lo_open >= 0) begin code = 4; bk = lo_open; end
        else if (k == K_RD && t - last_act[b] < T_RCD_RD) begin code = 5; bk = b; end
        else if (k == K_WR && t - last_act[b] < T_RCD_WR) begin code = 6; bk = b; end
        else if (k == K_ACT && t - last_act[b] < T_RC) begin code = 7; bk = b; end
        else if (k == K_ACT && rrd) begin code = 8; bk = b; end
        else if (ras_lo >= 0) begin code = 9; bk = ras_lo; end
        else if (k == K_ACT && t - last_pre[b] < T_RP) begin code = 10; bk = b; end
        else if ((k == K_REF || k == K_MRS) && rp_lo >= 0) begin code = 10; bk = rp_lo; end
        else if (is_real && t - last_ref < T_RFC) begin code = 11; bk = b; end
        else if (is_real && t - last_mrs < T_MRD) begin code = 12; bk = b; end
        else if (wr_lo >= 0) begin code = 13; bk = wr_lo; end
        else if (k == K_RD && t - last_wr_any <= hb_m) begin code = 14; bk = b; end
        else if (k == K_RD && t - last_wr_any < hb_m + T_CDLR) begin code = 15; bk = b; end
        // model update
        case (k)
            K_ACT: begin open_m[b] = 1; last_act[b] = t; end
            K_WR:  begin last_wr[b] = t; last_wr_any = t; end
            K_PRE: for (int c = 0; c < 4; c++)
                       if ((all || c == b) && open_m[c]) begin open_m[c] = 0; last_pre[c] = t; end
            K_REF: last_ref = t;
            K_MRS: begin
                last_mrs = t;
                if (b % 2 == 0) begin
                    if (mb == 1) hb_m = 1;
                    else if (mb == 2) hb_m = 2;
                    else if (mb == 3) hb_m = 4;
                end
            end
            default: ;
        endcase
        @(negedge clk);
        check_eq(int'(viol_o) * 256 + int'(viol_code_o) * 16 + (viol_o ? int'(viol_bank_o) : 0),
                 (code != 0 ? 256 : 0) + code * 16 + (code != 0 ? bk : 0),
                 tag_of(code), $sformatf("cycle %0d pulse*256+code*16+bank", t));
        t++;
    endtask

    task automatic cmd(input int kind, input int b, input bit all = 0, input int mb = 0);
        issue_raw(1'b0, kind, b, all, mb);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) cmd(K_NOP, 0);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            open_m[c] = 0; last_act[c] = -1000; last_pre[c] = -1000; last_wr[c] = -1000;
        end
        last_wr_any = -1000; last_ref = -1000; last_mrs = -1000; hb_m = 2;
        repeat (4) @(negedge clk);
        // R12 outputs cleared while reset is applied
        check_eq(int'(viol_o), 0, "R12", "pulse in reset");
        check_eq(int'(viol_code_o), 0, "R12", "code in reset");
        rst = 1'b0;
        nops(2);                                   // t0..t1
        cmd(K_RD, 1);                              // t2 idle read
        check_eq(int'(viol_code_o), 1, "R2", "read to idle bank");
        cmd(K_ACT, 0);                             // t3 first act, no window open (R12)
        check_eq(int'(viol_o), 0, "R12", "first activate after reset");
        cmd(K_ACT, 1);                             // t4
        check_eq(int'(viol_code_o), 8, "R5", "activate spacing across banks");
        cmd(K_WR, 1);                              // t5
        check_eq(int'(viol_code_o), 6, "R4", "write too soon after activate");
        cmd(K_RD, 0);                              // t6 rcd and in-burst both fail
        check_eq(int'(viol_code_o), 5, "R11", "rcd beats in-burst read");
        cmd(K_ACT, 0);                             // t7 open bank + tRC
        check_eq(int'(viol_code_o), 2, "R11", "open-bank code beats tRC");
        cmd(K_PRE, 0, 1);                          // t8 precharge all
        check_eq(int'(viol_code_o) * 4 + int'(viol_bank_o), 9 * 4 + 0, "R6", "tRAS lowest bank");
        cmd(K_REF, 0);                             // t9
        check_eq(int'(viol_code_o) * 4 + int'(viol_bank_o), 10 * 4 + 0, "R7", "refresh within tRP");
        nops(1);                                   // t10
        cmd(K_ACT, 2);                             // t11
        check_eq(int'(viol_code_o), 11, "R8", "activate within tRFC");
        cmd(K_REF, 0);                             // t12
        check_eq(int'(viol_code_o) * 4 + int'(viol_bank_o), 3 * 4 + 2, "R3", "refresh with bank 2 open");
        cmd(K_MRS, 0);                             // t13
        check_eq(int'(viol_code_o), 4, "R3", "mode set with bank open");
        cmd(K_PRE, 2);                             // t14 single-bank precharge
        nops(20);                                  // t15..t34
        cmd(K_MRS, 0, 0, 3);                       // t35 burst of 8
        cmd(K_ACT, 3);                             // t36
        check_eq(int'(viol_code_o), 12, "R8", "activate within tMRD");
        nops(3);                                   // t37..t39
        cmd(K_WR, 3);                              // t40
        cmd(K_RD, 3);                              // t41
        check_eq(int'(viol_code_o), 14, "R10", "read inside write burst");
        nops(2);                                   // t42..t43
        cmd(K_RD, 3);                              // t44 at burst end
        check_eq(int'(viol_code_o), 14, "R10", "read at last data cycle");
        cmd(K_RD, 3);                              // t45
        check_eq(int'(viol_code_o), 15, "R10", "read inside recovery");
        cmd(K_RD, 3);                              // t46
        check_eq(int'(viol_o), 0, "R10", "read at recovery limit");
        cmd(K_PRE, 3);                             // t47 at tWR limit
        check_eq(int'(viol_o), 0, "R10", "precharge at write recovery limit");
        nops(4);                                   // t48..t51
        cmd(K_ACT, 3);                             // t52
        nops(3);                                   // t53..t55
        cmd(K_WR, 3);                              // t56
        nops(3);                                   // t57..t59
        cmd(K_PRE, 3);                             // t60
        check_eq(int'(viol_code_o) * 4 + int'(viol_bank_o), 13 * 4 + 3, "R10", "precharge inside tWR");
        nops(4);                                   // t61..t64
        cmd(K_MRS, 1, 0, 1);                       // t65 extended set, burst kept
        nops(1);                                   // t66
        cmd(K_ACT, 0);                             // t67
        nops(1);                                   // t68
        cmd(K_WR, 0);                              // t69
        nops(3);                                   // t70..t72
        cmd(K_RD, 0);                              // t73
        check_eq(int'(viol_code_o), 14, "R9", "extended mode set leaves burst length");
        issue_raw(1'b1, K_ACT, 1, 0, 0);           // t74 deselected activate
        check_eq(int'(viol_o), 0, "R1", "deselected cycle quiet");
        cmd(K_RD, 1);                              // t75
        check_eq(int'(viol_code_o), 1, "R1", "deselected activate not decoded");
        nops(1);
        check_eq(int'(viol_o), 0, "R1", "pulse lasts one cycle");
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule